// File: doc/BRIEF.md
# DMA Channel Command and Status Register Block

This block is the software-visible register slice of one DMA channel. It sits in a 64-byte channel window on a simple 32-bit register bus and is the only path software has to steer the transfer engine. Writes to the command register carry one-shot actions: separate set and clear bits for the channel enable and suspend flags, a software transfer trigger, a channel soft reset, a pending-request clear, and clear bits for the completion flags. The command register always reads back as zero.

The engine reports back through single-cycle event pulses (end of transfer, terminal count, error, descriptor error) and a level that shows a transfer is in flight. The block turns these pulses into sticky flags in a status word. It also passes through the engine's residual byte count, and it holds a configuration word whose block-mode bit decides whether a software trigger reaches the engine. To abort a channel, software clears enable, waits until the active bit drops, then issues a soft reset.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the enable, suspend, end, terminal-count, error and descriptor-error flags are zero, the configuration word is zero, and the trigger, soft-reset and request-clear pulses are low.
- R2: Reads are decoded on exact byte offsets. 0x20 returns the residual count input, 0x24 returns the status word, 0x2C returns the configuration word, and 0x28 (command) reads as zero, as does every other offset.
- R3: In a command write, bit 0 sets enable and bit 1 clears it. The clear wins when both are written. Enable shows in status bit 0 from the cycle after the write.
- R4: Command bit 8 sets suspend and bit 9 clears it, with the clear winning, and the state drives `chan_suspend`. Enable-set and suspend-clear in one write both take effect.
- R5: The end flag (status bit 5) and terminal-count flag (status bit 6) are set by a one-cycle engine pulse and hold until command bit 5 or bit 6 clears them. An event in the same cycle as its clear leaves the flag set.
- R6: The error flag (status bit 4) and descriptor-error flag (status bit 10) are set by engine pulses. They are not affected by the end or terminal-count clear commands.
- R7: Command bit 3 raises `chan_soft_reset` for one cycle. From the next cycle it zeroes enable, suspend, end, terminal-count, error and descriptor-error, and it overrides any set bits or events in the same cycle.
- R8: Command bit 2 raises `chan_trigger` for one cycle, but only while configuration bit 22 (block mode) is one. Otherwise it has no effect.
- R9: Command bit 4 raises `chan_req_clear` for one cycle.
- R10: Status bit 2 follows the engine's transfer-active input in the same cycle.
- R11: The configuration word at 0x2C is read/write and drives `chan_cfg`.
- R12: Writes to the residual (0x20) and status (0x24) offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset within the channel window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| eng_active | input | 1 | Engine has a transfer in flight |
| eng_end | input | 1 | One-cycle end-of-transfer event |
| eng_tc | input | 1 | One-cycle terminal-count event |
| eng_err | input | 1 | One-cycle transfer error event |
| eng_desc_err | input | 1 | One-cycle descriptor error event |
| eng_residual | input | DATA_W | Residual byte count of the current transfer |
| chan_enable | output | 1 | Channel enable to the engine |
| chan_suspend | output | 1 | Channel suspend to the engine |
| chan_trigger | output | 1 | Software transfer trigger pulse |
| chan_soft_reset | output | 1 | Channel soft-reset pulse |
| chan_req_clear | output | 1 | Pending-request clear pulse |
| chan_cfg | output | DATA_W | Configuration word |

## Verification
A table of command words and event pulses runs through one sequence. Lone set bits, lone clear bits and set-plus-clear pairs in a single write separate the clear-wins rule from the set-wins rule. Events that land in the same cycle as their own clear separate sticky capture from command priority. Soft reset is tried both alone and together with set bits and events, which shows that it overrides everything. Directed cases then write the trigger with block mode on and off, read every offset including unmapped ones, and write the read-only offsets to show they change nothing.

// File: rtl/chan_regs_pkg.sv
package chan_regs_pkg;

  // byte offsets inside the channel window
  localparam int OFF_RESID = 'h20;
  localparam int OFF_STAT  = 'h24;
  localparam int OFF_CTRL  = 'h28;
  localparam int OFF_CFG   = 'h2C;

  // command bit positions
  localparam int CB_SET_EN  = 0;
  localparam int CB_CLR_EN  = 1;
  localparam int CB_TRIG    = 2;
  localparam int CB_SRST    = 3;
  localparam int CB_CLR_REQ = 4;
  localparam int CB_CLR_END = 5;
  localparam int CB_CLR_TC  = 6;
  localparam int CB_SET_SUS = 8;
  localparam int CB_CLR_SUS = 9;

  // status bit positions
  localparam int SB_EN   = 0;
  localparam int SB_ACT  = 2;
  localparam int SB_ERR  = 4;
  localparam int SB_END  = 5;
  localparam int SB_TC   = 6;
  localparam int SB_DERR = 10;

  // configuration bit that selects block transfer mode
  localparam int CFG_BLOCK_BIT = 22;

  // flag slots
  localparam int F_EN    = 0;
  localparam int F_SUS   = 1;
  localparam int F_END   = 2;
  localparam int F_TC    = 3;
  localparam int F_ERR   = 4;
  localparam int F_DERR  = 5;
  localparam int NFLAG   = 6;

  typedef struct packed {
    logic set_en;
    logic clr_en;
    logic trig;
    logic srst;
    logic clr_req;
    logic clr_end;
    logic clr_tc;
    logic set_sus;
    logic clr_sus;
    logic cfg_we;
  } chan_cmd_t;

  // next state of one flag: soft reset first, then the set/clear conflict rule
  function automatic logic flag_next(input logic q, input logic set,
                                     input logic clr, input logic srst,
                                     input logic set_wins);
    logic n;
    if (srst)              n = 1'b0;
    else if (set && clr)   n = set_wins;
    else if (set)          n = 1'b1;
    else if (clr)          n = 1'b0;
    else                   n = q;
    return n;
  endfunction

endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode
  import chan_regs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              block_mode,
  output chan_cmd_t         cmd
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);

  logic ctrl_hit;
  logic unused_bits;

  assign ctrl_hit    = bus_wr && (bus_addr == A_CTRL);
  assign unused_bits = ^{bus_wdata[DATA_W-1:CB_CLR_SUS+1], bus_wdata[7]};

  always_comb begin
    cmd         = '0;
    cmd.set_en  = ctrl_hit && bus_wdata[CB_SET_EN];
    cmd.clr_en  = ctrl_hit && bus_wdata[CB_CLR_EN];
    cmd.trig    = ctrl_hit && bus_wdata[CB_TRIG] && block_mode;
    cmd.srst    = ctrl_hit && bus_wdata[CB_SRST];
    cmd.clr_req = ctrl_hit && bus_wdata[CB_CLR_REQ];
    cmd.clr_end = ctrl_hit && bus_wdata[CB_CLR_END];
    cmd.clr_tc  = ctrl_hit && bus_wdata[CB_CLR_TC];
    cmd.set_sus = ctrl_hit && bus_wdata[CB_SET_SUS];
    cmd.clr_sus = ctrl_hit && bus_wdata[CB_CLR_SUS];
    cmd.cfg_we  = bus_wr && (bus_addr == A_CFG);
  end

endmodule

// File: rtl/chan_flag_cell.sv
module chan_flag_cell
  import chan_regs_pkg::*;
#(
  parameter bit SET_WINS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic srst_i,
  output logic q_o
);

  logic q_nx;
  assign q_nx = flag_next(q_o, set_i, clr_i, srst_i, SET_WINS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_nx;
  end

  // R7: soft reset empties the flag on the next edge
  p_flag_srst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> !q_o);

  // R5: a set flag holds while neither its clear nor soft reset arrives
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clr_i && !srst_i) |=> q_o);

  // R3: an uncontested set is taken
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i && !srst_i) |=> q_o);

endmodule

// File: rtl/chan_read_mux.sv
module chan_read_mux
  import chan_regs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] residual,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] cfg,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] A_RESID = ADDR_W'(OFF_RESID);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);

  always_comb begin
    unique case (bus_addr)
      A_RESID: rdata = residual;
      A_STAT:  rdata = status;
      A_CFG:   rdata = cfg;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import chan_regs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_active,
  input  logic              eng_end,
  input  logic              eng_tc,
  input  logic              eng_err,
  input  logic              eng_desc_err,
  input  logic [DATA_W-1:0] eng_residual,
  output logic              chan_enable,
  output logic              chan_suspend,
  output logic              chan_trigger,
  output logic              chan_soft_reset,
  output logic              chan_req_clear,
  output logic [DATA_W-1:0] chan_cfg
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  // slots where an engine event beats a clear command in the same cycle
  localparam logic [NFLAG-1:0] SET_WINS_MASK =
    NFLAG'((1 << F_END) | (1 << F_TC));

  chan_cmd_t         cmd;
  logic [NFLAG-1:0]  f_set, f_clr, flags;
  logic [DATA_W-1:0] cfg_q, status_w;
  logic              trig_q, srst_q, reqclr_q;

  chan_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .block_mode (cfg_q[CFG_BLOCK_BIT]),
    .cmd        (cmd)
  );

  always_comb begin
    f_set = '0;
    f_clr = '0;
    f_set[F_EN]   = cmd.set_en;
    f_clr[F_EN]   = cmd.clr_en;
    f_set[F_SUS]  = cmd.set_sus;
    f_clr[F_SUS]  = cmd.clr_sus;
    f_set[F_END]  = eng_end;
    f_clr[F_END]  = cmd.clr_end;
    f_set[F_TC]   = eng_tc;
    f_clr[F_TC]   = cmd.clr_tc;
    f_set[F_ERR]  = eng_err;
    f_set[F_DERR] = eng_desc_err;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    chan_flag_cell #(.SET_WINS(SET_WINS_MASK[i])) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (f_set[i]),
      .clr_i  (f_clr[i]),
      .srst_i (cmd.srst),
      .q_o    (flags[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      trig_q   <= 1'b0;
      srst_q   <= 1'b0;
      reqclr_q <= 1'b0;
    end else begin
      if (cmd.cfg_we) cfg_q <= bus_wdata;
      trig_q   <= cmd.trig;
      srst_q   <= cmd.srst;
      reqclr_q <= cmd.clr_req;
    end
  end

  always_comb begin
    status_w          = '0;
    status_w[SB_EN]   = flags[F_EN];
    status_w[SB_ACT]  = eng_active;
    status_w[SB_ERR]  = flags[F_ERR];
    status_w[SB_END]  = flags[F_END];
    status_w[SB_TC]   = flags[F_TC];
    status_w[SB_DERR] = flags[F_DERR];
  end

  chan_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .bus_addr (bus_addr),
    .residual (eng_residual),
    .status   (status_w),
    .cfg      (cfg_q),
    .rdata    (bus_rdata)
  );

  assign chan_enable     = flags[F_EN];
  assign chan_suspend    = flags[F_SUS];
  assign chan_trigger    = trig_q;
  assign chan_soft_reset = srst_q;
  assign chan_req_clear  = reqclr_q;
  assign chan_cfg        = cfg_q;

  // R3: a command write carrying the enable-clear bit leaves enable low
  p_clr_en_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && bus_wdata[CB_CLR_EN]) |=> !chan_enable);

  // R4: a command write carrying the suspend-clear bit leaves suspend low
  p_clr_sus_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && bus_wdata[CB_CLR_SUS]) |=> !chan_suspend);

  // R7: while the soft-reset pulse is out, enable and suspend are already low
  p_srst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_soft_reset |-> (!chan_enable && !chan_suspend));

  // R8: a trigger pulse is only seen with block mode selected
  p_trig_block_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chan_trigger |-> chan_cfg[CFG_BLOCK_BIT]);

  // R9: a request-clear pulse follows a command write with bit 4
  p_reqclr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chan_req_clear |-> $past(bus_wr && bus_addr == A_CTRL && bus_wdata[CB_CLR_REQ]));

endmodule

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_active = 1'b0, eng_end = 1'b0, eng_tc = 1'b0;
  logic        eng_err = 1'b0, eng_desc_err = 1'b0;
  logic [31:0] eng_residual = '0;
  logic        chan_enable, chan_suspend, chan_trigger;
  logic        chan_soft_reset, chan_req_clear;
  logic [31:0] chan_cfg;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  dma_chan_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_active(eng_active),
    .eng_end(eng_end), .eng_tc(eng_tc), .eng_err(eng_err),
    .eng_desc_err(eng_desc_err), .eng_residual(eng_residual),
    .chan_enable(chan_enable), .chan_suspend(chan_suspend),
    .chan_trigger(chan_trigger), .chan_soft_reset(chan_soft_reset),
    .chan_req_clear(chan_req_clear), .chan_cfg(chan_cfg)
  );

  // {command[15:0], events {desc_err,err,tc,end}[3:0], status[10:0], suspend}
  localparam int NV = 19;
  localparam logic [31:0] VEC [NV] = '{
    {16'h0001, 4'h0, 11'h001, 1'b0},  // R3 set enable
    {16'h0100, 4'h0, 11'h001, 1'b1},  // R4 set suspend
    {16'h0002, 4'h0, 11'h000, 1'b1},  // R3 clear enable
    {16'h0201, 4'h0, 11'h001, 1'b0},  // R4 enable-set with suspend-clear
    {16'h0003, 4'h0, 11'h000, 1'b0},  // R3 clear wins
    {16'h0300, 4'h0, 11'h000, 1'b0},  // R4 clear wins
    {16'h0000, 4'h1, 11'h020, 1'b0},  // R5 end event
    {16'h0000, 4'h2, 11'h060, 1'b0},  // R5 tc event
    {16'h0020, 4'h0, 11'h040, 1'b0},  // R5 clear end
    {16'h0040, 4'h2, 11'h040, 1'b0},  // R5 event beats clear
    {16'h0040, 4'h0, 11'h000, 1'b0},  // R5 clear tc
    {16'h0000, 4'h4, 11'h010, 1'b0},  // R6 error event
    {16'h0060, 4'h0, 11'h010, 1'b0},  // R6 error survives end/tc clears
    {16'h0000, 4'h8, 11'h410, 1'b0},  // R6 descriptor error
    {16'h0101, 4'h0, 11'h411, 1'b1},  // R3 R4 set both
    {16'h0000, 4'h1, 11'h431, 1'b1},  // R5 end on top
    {16'h0008, 4'h0, 11'h000, 1'b0},  // R7 soft reset
    {16'h0109, 4'h0, 11'h000, 1'b0},  // R7 beats set bits
    {16'h0008, 4'h1, 11'h000, 1'b0}   // R7 beats events
  };

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic wr, input logic [5:0] a,
                       input logic [31:0] d, input logic [3:0] ev);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    {eng_desc_err, eng_err, eng_tc, eng_end} = ev;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    {eng_desc_err, eng_err, eng_tc, eng_end} = 4'h0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h24, v); check("R1 status", v, 32'h0);
    check("R1 cfg", chan_cfg, 32'h0);
    check("R1 outputs", {27'h0, chan_enable, chan_suspend, chan_trigger,
                         chan_soft_reset, chan_req_clear}, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][31:16] != 16'h0, 6'h28, {16'h0, VEC[i][31:16]}, VEC[i][15:12]);
      rd(6'h24, v);
      check($sformatf("R3/R4/R5/R6/R7 row %0d status", i), v, {21'h0, VEC[i][11:1]});
      check($sformatf("R4 row %0d suspend", i), {31'h0, chan_suspend}, {31'h0, VEC[i][0]});
    end

    // R2 decode
    eng_residual = 32'h1234_5678;
    rd(6'h20, v); check("R2 residual", v, 32'h1234_5678);
    rd(6'h28, v); check("R2 control reads zero", v, 32'h0);
    rd(6'h00, v); check("R2 unmapped 0x00", v, 32'h0);
    rd(6'h30, v); check("R2 unmapped 0x30", v, 32'h0);
    rd(6'h22, v); check("R2 unaligned 0x22", v, 32'h0);

    // R10 active bit follows input
    eng_active = 1'b1;
    rd(6'h24, v); check("R10 active high", v, 32'h004);
    eng_active = 1'b0;
    rd(6'h24, v); check("R10 active low", v, 32'h000);

    // R11 configuration
    apply(1'b1, 6'h2C, 32'h0040_00A5, 4'h0);
    rd(6'h2C, v); check("R11 cfg readback", v, 32'h0040_00A5);
    check("R11 cfg port", chan_cfg, 32'h0040_00A5);

    // R8 trigger with block mode on
    apply(1'b1, 6'h28, 32'h4, 4'h0);
    check("R8 trigger pulse", {31'h0, chan_trigger}, 32'h1);
    @(negedge clk);
    check("R8 trigger one cycle", {31'h0, chan_trigger}, 32'h0);
    // R8 trigger with block mode off
    apply(1'b1, 6'h2C, 32'h0000_00A5, 4'h0);
    apply(1'b1, 6'h28, 32'h4, 4'h0);
    check("R8 trigger ignored", {31'h0, chan_trigger}, 32'h0);

    // R9 request clear pulse
    apply(1'b1, 6'h28, 32'h10, 4'h0);
    check("R9 req clear pulse", {31'h0, chan_req_clear}, 32'h1);
    @(negedge clk);
    check("R9 req clear one cycle", {31'h0, chan_req_clear}, 32'h0);

    // R7 soft reset pulse
    apply(1'b1, 6'h28, 32'h8, 4'h0);
    check("R7 soft reset pulse", {31'h0, chan_soft_reset}, 32'h1);
    @(negedge clk);
    check("R7 soft reset one cycle", {31'h0, chan_soft_reset}, 32'h0);

    // R12 writes to read-only offsets
    apply(1'b1, 6'h28, 32'h1, 4'h0);
    apply(1'b1, 6'h24, 32'hFFFF_FFFF, 4'h0);
    apply(1'b1, 6'h20, 32'hFFFF_FFFF, 4'h0);
    rd(6'h24, v); check("R12 status unchanged", v, 32'h001);
    check("R12 suspend unchanged", {31'h0, chan_suspend}, 32'h0);
    rd(6'h20, v); check("R12 residual unchanged", v, 32'h1234_5678);
    check("R12 cfg unchanged", chan_cfg, 32'h0000_00A5);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule